// File: doc/BRIEF.md
# Byte ALU with Status Word

This block is the arithmetic and logic datapath of a small 8-bit processor core. It evaluates one operation per cycle on two byte operands. The second operand may come from a register or from an immediate field; the block does not care which. The result and its write-back enable are combinational, so the register file can capture them at the same edge that retires the operation.

The block holds an eight-bit status word. The word has six arithmetic flags, one user bit and one interrupt-enable bit. Each operation computes a next status word from the current one and updates only the flags it is defined to affect. The status word is registered on the next rising clock edge. Compare operations produce flags without a write-back. Dedicated operations set or clear any single status bit chosen by a 3-bit index.

Status bit positions: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Operation codes appear on `op_i` as unsigned values, listed in the requirements below.

Top module: `byte_alu_status`

## Requirements
- R1: During reset (`rst_ni` low) the status word clears to 0x00, and `status_o` reads 0x00 after reset is released.
- R2: Add (1) and add-with-carry (2) return a+b and a+b+C. Subtract (3) and subtract-with-carry (4) return a-b and a-b-C. All four update C (carry or borrow out of bit 7), H (carry or borrow out of bit 3), V (signed overflow), N (bit 7), Z and S, and they assert write-back.
- R3: Compare (5) and compare-with-carry (6) update the same flags as codes 3 and 4, and `wr_en_o` stays 0.
- R4: For codes 4 and 6, Z becomes 1 only if the difference is zero and Z was already 1. Otherwise Z becomes 0.
- R5: AND (7), OR (8) and XOR (9) clear V and update Z, N and S. C, H, T and I are left unchanged.
- R6: Increment (12) and decrement (13) update Z, N, V and S, and leave C and H unchanged. V is 1 only when increment starts from 0x7F or decrement starts from 0x80.
- R7: Complement (10) returns 0xFF-a, sets C and clears V, and leaves H unchanged. Negate (11) returns 0x00-a, with C=1 iff the result is nonzero, V=1 iff the result is 0x80, and H as the borrow out of bit 3.
- R8: Shift left (14) inserts 0 and rotate left (16) inserts the old C into bit 0. Both move bit 7 into C and bit 3 into H, and both compute V as N xor C.
- R9: Shift right (15) inserts 0 into bit 7, rotate right (17) inserts the old C, and arithmetic shift right (18) repeats bit 7. All three move bit 0 into C, compute V as N xor C, and leave H unchanged.
- R10: Nibble swap (19) returns the operand with its upper and lower nibbles exchanged, and pass (22) returns operand b. Both write back and leave all eight status bits unchanged.
- R11: Flag set (20) and flag clear (21) write 1 or 0 into the status bit indexed by `fsel_i`. No other bit changes, and no write-back is asserted.
- R12: `status_o` takes the value `status_next_o` had one rising edge earlier. No-op (0) writes nothing and changes no status bit.
- R13: Every operation that updates S leaves S equal to N xor V of the new status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | First operand (destination register value) |
| opb_i | input | 8 | Second operand (register or immediate) |
| fsel_i | input | 3 | Status bit index for flag set and clear |
| result_o | output | 8 | Operation result, combinational |
| wr_en_o | output | 1 | Result write-back enable, combinational |
| status_next_o | output | 8 | Status word after this operation, combinational |
| status_o | output | 8 | Registered status word |

## Verification
The result, the write-back enable and the next status word respond in the same cycle the operands change, with no register in the path. The bench drives each operation just after a falling edge and samples these three outputs one nanosecond later, well before the following rising edge. The registered status word is due one rising edge later, so the bench compares it one nanosecond after that edge. The bench's model then adopts the new status word, so carry-in and sticky-Z inputs always come from the design's true prior state.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    parameter int DATA_W = 8;
    parameter int SR_W   = 8;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    localparam logic [SR_W-1:0] M_FULL  = 8'b0011_1111;
    localparam logic [SR_W-1:0] M_LOGIC = 8'b0001_1110;
    localparam logic [SR_W-1:0] M_CZNVS = 8'b0001_1111;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADDC = 5'd2,
        OP_SUB  = 5'd3,
        OP_SUBC = 5'd4,
        OP_CMP  = 5'd5,
        OP_CMPC = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_INV  = 5'd10,
        OP_NEG  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_SHL  = 5'd14,
        OP_SHR  = 5'd15,
        OP_RCL  = 5'd16,
        OP_RCR  = 5'd17,
        OP_SAR  = 5'd18,
        OP_NSWP = 5'd19,
        OP_FSET = 5'd20,
        OP_FCLR = 5'd21,
        OP_PASS = 5'd22
    } alu_op_e;

    // contribution of one functional unit: result, new flag values, update mask
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [SR_W-1:0]   flg;
        logic [SR_W-1:0]   upd;
    } unit_out_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        logic [SR_W-1:0]   sr;
    } step_t;

    function automatic logic op_writes(input alu_op_e op);
        return !(op == OP_NOP || op == OP_CMP || op == OP_CMPC ||
                 op == OP_FSET || op == OP_FCLR);
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic           zin,
    output unit_out_t      out
);
    localparam int HALF = W / 2;

    logic         hit, is_sub, use_c, sticky_z, ce;
    logic [W-1:0] x, y, r;
    logic [W:0]   full;
    logic [HALF:0] lo;
    logic         c, h, v, n, z;

    always_comb begin
        hit      = 1'b1;
        is_sub   = 1'b0;
        use_c    = 1'b0;
        sticky_z = 1'b0;
        x        = a;
        y        = b;
        case (op)
            OP_ADD:  ;
            OP_ADDC: use_c = 1'b1;
            OP_SUB,
            OP_CMP:  is_sub = 1'b1;
            OP_SUBC,
            OP_CMPC: begin is_sub = 1'b1; use_c = 1'b1; sticky_z = 1'b1; end
            OP_NEG:  begin is_sub = 1'b1; x = '0; y = a; end
            default: hit = 1'b0;
        endcase
        ce = use_c & cin;
        if (is_sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ce};
            lo   = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, ce};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ce};
            lo   = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ce};
        end
        r = full[W-1:0];
        c = full[W];
        h = lo[HALF];
        if (is_sub) v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
        else        v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
        n = r[W-1];
        z = (r == '0) && (!sticky_z || zin);

        out          = '0;
        if (hit) begin
            out.res       = r;
            out.flg[FL_C] = c;
            out.flg[FL_Z] = z;
            out.flg[FL_N] = n;
            out.flg[FL_V] = v;
            out.flg[FL_S] = n ^ v;
            out.flg[FL_H] = h;
            out.upd       = M_FULL;
        end
    end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output unit_out_t    out
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic         hit, v;
    logic [W-1:0] r;
    logic [SR_W-1:0] mask;

    always_comb begin
        hit  = 1'b1;
        v    = 1'b0;
        r    = '0;
        mask = M_LOGIC;
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_INV:  begin r = ~a; mask = M_CZNVS; end
            OP_INC:  begin r = a + ONE; v = (a == MAX_POS); end
            OP_DEC:  begin r = a - ONE; v = (a == MIN_NEG); end
            OP_PASS: begin r = b; mask = '0; end
            default: hit = 1'b0;
        endcase

        out = '0;
        if (hit) begin
            out.res       = r;
            out.flg[FL_C] = 1'b1;
            out.flg[FL_Z] = (r == '0);
            out.flg[FL_N] = r[W-1];
            out.flg[FL_V] = v;
            out.flg[FL_S] = r[W-1] ^ v;
            out.upd       = mask;
        end
    end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output unit_out_t    out
);
    localparam int HALF = W / 2;

    logic         hit, c, n;
    logic [W-1:0] r;
    logic [SR_W-1:0] mask;

    always_comb begin
        hit  = 1'b1;
        c    = 1'b0;
        r    = '0;
        mask = M_CZNVS;
        case (op)
            OP_SHL:  begin r = {a[W-2:0], 1'b0};     c = a[W-1]; mask = M_FULL; end
            OP_RCL:  begin r = {a[W-2:0], cin};      c = a[W-1]; mask = M_FULL; end
            OP_SHR:  begin r = {1'b0, a[W-1:1]};     c = a[0]; end
            OP_RCR:  begin r = {cin, a[W-1:1]};      c = a[0]; end
            OP_SAR:  begin r = {a[W-1], a[W-1:1]};   c = a[0]; end
            OP_NSWP: begin r = {a[HALF-1:0], a[W-1:HALF]}; mask = '0; end
            default: hit = 1'b0;
        endcase
        n = r[W-1];

        out = '0;
        if (hit) begin
            out.res       = r;
            out.flg[FL_C] = c;
            out.flg[FL_Z] = (r == '0);
            out.flg[FL_N] = n;
            out.flg[FL_V] = n ^ c;
            out.flg[FL_S] = c;        // N ^ (N ^ C)
            out.flg[FL_H] = a[HALF-1];
            out.upd       = mask;
        end
    end
endmodule

// File: rtl/byte_alu_flagop.sv
module byte_alu_flagop
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e                   op,
    input  logic [$clog2(SR_W)-1:0]   sel,
    output unit_out_t                 out
);
    localparam int SEL_W = $clog2(SR_W);

    logic is_set, is_clr;
    assign is_set = (op == OP_FSET);
    assign is_clr = (op == OP_FCLR);

    assign out.res = '0;

    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        assign out.upd[i] = (is_set || is_clr) && (sel == SEL_W'(i));
        assign out.flg[i] = is_set;
    end
endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [2:0]    fsel_i,
    output logic [W-1:0]  result_o,
    output logic          wr_en_o,
    output logic [SR_W-1:0] status_next_o,
    output logic [SR_W-1:0] status_o
);
    alu_op_e         op;
    unit_out_t       u_as, u_lg, u_sh, u_fl;
    step_t           step_d;
    logic [SR_W-1:0] status_d, status_q;
    logic [SR_W-1:0] upd_all, flg_all;

    assign op = alu_op_e'(op_i);

    byte_alu_addsub #(.W(W)) u_addsub (
        .op  (op),
        .a   (opa_i),
        .b   (opb_i),
        .cin (status_q[FL_C]),
        .zin (status_q[FL_Z]),
        .out (u_as)
    );

    byte_alu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (opa_i),
        .b   (opb_i),
        .out (u_lg)
    );

    byte_alu_shift #(.W(W)) u_shift (
        .op  (op),
        .a   (opa_i),
        .cin (status_q[FL_C]),
        .out (u_sh)
    );

    byte_alu_flagop #(.W(W)) u_flagop (
        .op  (op),
        .sel (fsel_i),
        .out (u_fl)
    );

    always_comb begin
        upd_all   = u_as.upd | u_lg.upd | u_sh.upd | u_fl.upd;
        flg_all   = (u_as.flg & u_as.upd) | (u_lg.flg & u_lg.upd) |
                    (u_sh.flg & u_sh.upd) | (u_fl.flg & u_fl.upd);
        step_d.res = u_as.res | u_lg.res | u_sh.res | u_fl.res;
        step_d.wr  = op_writes(op);
        step_d.sr  = (status_q & ~upd_all) | flg_all;
        status_d   = step_d.sr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= status_d;
    end

    assign result_o      = step_d.res;
    assign wr_en_o       = step_d.wr;
    assign status_next_o = step_d.sr;
    assign status_o      = status_q;
endmodule

// File: rtl/byte_alu_status_chk.sv
module byte_alu_status_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [4:0] op_i,
    input logic       wr_en_o,
    input logic [7:0] status_next_o,
    input logic [7:0] status_o
);
    a_r3_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd5 || op_i == 5'd6) |-> !wr_en_o);

    a_r12_status_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> status_o == $past(status_next_o));

    a_r12_nop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd0) |-> (status_next_o == status_o && !wr_en_o));

    a_r5_logic_keeps_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 5'd7 && op_i <= 5'd9) |->
        (status_next_o[0] == status_o[0] && status_next_o[5] == status_o[5] && !status_next_o[3]));

    a_r4_sticky_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == 5'd4 || op_i == 5'd6) && !status_o[1]) |-> !status_next_o[1]);

    a_r10_swap_pass_noflags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd19 || op_i == 5'd22) |-> (status_next_o == status_o && wr_en_o));

    a_r11_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd20 || op_i == 5'd21) |->
        ($countones(status_next_o ^ status_o) <= 1 && !wr_en_o));

    a_r13_sign_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 5'd1 && op_i <= 5'd18) |->
        status_next_o[4] == (status_next_o[2] ^ status_next_o[3]));
endmodule

bind byte_alu_status byte_alu_status_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op_i),
    .wr_en_o       (wr_en_o),
    .status_next_o (status_next_o),
    .status_o      (status_o)
);

// File: tb/byte_alu_status_tb.sv
`timescale 1ns/1ps
module byte_alu_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] a = 8'h00, b = 8'h00;
    logic [2:0] sel = 3'd0;
    logic [7:0] res, sr_nx, sr;
    logic       wr;
    int         vecs = 0, errs = 0;
    logic [7:0] msr = 8'h00;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    byte_alu_status u_dut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .fsel_i(sel), .result_o(res), .wr_en_o(wr),
        .status_next_o(sr_nx), .status_o(sr)
    );

    // reference: returns {write, result, next status}
    function automatic logic [16:0] model(input logic [4:0] o, input logic [7:0] x0,
                                          input logic [7:0] y0, input logic [2:0] s,
                                          input logic [7:0] st);
        logic [7:0] r, f, x, y;
        logic w;
        int cc, t, sv;
        f = st; r = 8'h00; w = 1'b1; cc = int'(st[0]); x = x0; y = y0;
        case (o)
            5'd1, 5'd2: begin
                if (o == 5'd1) cc = 0;
                t = int'(x) + int'(y) + cc; r = t[7:0];
                f[0] = t > 255;
                f[5] = (int'(x & 8'h0f) + int'(y & 8'h0f) + cc) > 15;
                sv = int'($signed(x)) + int'($signed(y)) + cc;
                f[3] = (sv > 127) || (sv < -128);
                f[1] = (r == 8'h00); f[2] = r[7]; f[4] = f[2] ^ f[3];
            end
            5'd3, 5'd4, 5'd5, 5'd6, 5'd11: begin
                if (o == 5'd11) begin x = 8'h00; y = x0; end
                if (o == 5'd3 || o == 5'd5 || o == 5'd11) cc = 0;
                t = int'(x) - int'(y) - cc; r = t[7:0];
                f[0] = t < 0;
                f[5] = (int'(x & 8'h0f) - int'(y & 8'h0f) - cc) < 0;
                sv = int'($signed(x)) - int'($signed(y)) - cc;
                f[3] = (sv > 127) || (sv < -128);
                f[1] = (o == 5'd4 || o == 5'd6) ? ((r == 8'h00) && st[1]) : (r == 8'h00);
                f[2] = r[7]; f[4] = f[2] ^ f[3];
                w = !(o == 5'd5 || o == 5'd6);
            end
            5'd7, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13: begin
                case (o)
                    5'd7:  r = x & y;
                    5'd8:  r = x | y;
                    5'd9:  r = x ^ y;
                    5'd10: r = 8'hff - x;
                    5'd12: r = x + 8'd1;
                    default: r = x - 8'd1;
                endcase
                f[3] = (o == 5'd12 && x == 8'h7f) || (o == 5'd13 && x == 8'h80);
                if (o == 5'd10) f[0] = 1'b1;
                f[1] = (r == 8'h00); f[2] = r[7]; f[4] = f[2] ^ f[3];
            end
            5'd14, 5'd15, 5'd16, 5'd17, 5'd18: begin
                case (o)
                    5'd14: r = x << 1;
                    5'd16: r = (x << 1) | {7'd0, st[0]};
                    5'd15: r = x >> 1;
                    5'd17: r = (x >> 1) | {st[0], 7'd0};
                    default: r = (x >> 1) | (x & 8'h80);
                endcase
                f[0] = (o == 5'd14 || o == 5'd16) ? x[7] : x[0];
                if (o == 5'd14 || o == 5'd16) f[5] = x[3];
                f[1] = (r == 8'h00); f[2] = r[7]; f[3] = f[2] ^ f[0]; f[4] = f[2] ^ f[3];
            end
            5'd19: r = {x[3:0], x[7:4]};
            5'd22: r = y;
            5'd20: begin f[s] = 1'b1; w = 1'b0; end
            5'd21: begin f[s] = 1'b0; w = 1'b0; end
            default: w = 1'b0;
        endcase
        return {w, r, f};
    endfunction

    task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic [2:0] s, input string tag);
        logic [16:0] e;
        @(negedge clk);
        op = o; a = x; b = y; sel = s;
        #1;
        e = model(o, x, y, s, msr);
        vecs++;
        if (wr !== e[16]) begin
            errs++; $display("FAIL %s op=%0d wr_en got %b exp %b", tag, o, wr, e[16]);
        end
        if (e[16] && res !== e[15:8]) begin
            errs++; $display("FAIL %s op=%0d a=%h b=%h result got %h exp %h", tag, o, x, y, res, e[15:8]);
        end
        if (sr_nx !== e[7:0]) begin
            errs++; $display("FAIL %s op=%0d a=%h b=%h sr_in=%h status_next got %h exp %h",
                             tag, o, x, y, msr, sr_nx, e[7:0]);
        end
        @(posedge clk); #1;
        if (sr !== e[7:0]) begin
            errs++; $display("FAIL R12 op=%0d status_o got %h exp %h", o, sr, e[7:0]);
        end
        msr = e[7:0];
    endtask

    task automatic load_status(input logic [7:0] v);
        for (int i = 0; i < 8; i++)
            apply(v[i] ? 5'd20 : 5'd21, 8'h00, 8'h00, 3'(i), "R11");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        vecs++;
        if (sr !== 8'h00) begin errs++; $display("FAIL R1 status_o got %h exp 00", sr); end
        @(negedge clk); rst_n = 1'b1;
        msr = 8'h00;
        apply(5'd0, 8'h12, 8'h34, 3'd0, "R12");
    endtask

    task automatic t_addsub;   // R2, R13
        apply(5'd1, 8'h7f, 8'h01, 3'd0, "R2");
        apply(5'd1, 8'hff, 8'h01, 3'd0, "R2");
        apply(5'd2, 8'h0f, 8'h00, 3'd0, "R2");
        apply(5'd3, 8'h80, 8'h01, 3'd0, "R2");
        apply(5'd4, 8'h00, 8'h00, 3'd0, "R2");
        for (int i = 0; i < 60; i++) begin
            load_status(8'($urandom()));
            apply(5'(1 + (i % 4)), 8'($urandom()), 8'($urandom()), 3'd0, "R2");
        end
    endtask

    task automatic t_compare;  // R3, R4
        apply(5'd5, 8'h10, 8'h20, 3'd0, "R3");
        apply(5'd5, 8'h33, 8'h33, 3'd0, "R3");
        load_status(8'h01);    // C=1, Z=0
        apply(5'd6, 8'h34, 8'h33, 3'd0, "R4");  // diff 0 but Z was 0
        load_status(8'h03);    // C=1, Z=1
        apply(5'd6, 8'h34, 8'h33, 3'd0, "R4");  // Z held
        load_status(8'h00);
        apply(5'd4, 8'h55, 8'h55, 3'd0, "R4");
        load_status(8'h02);
        apply(5'd4, 8'h56, 8'h55, 3'd0, "R4");  // nonzero clears Z
        for (int i = 0; i < 30; i++) begin
            load_status(8'($urandom()));
            apply(5'(5 + (i % 2)), 8'($urandom()), 8'($urandom()), 3'd0, "R3");
        end
    endtask

    task automatic t_logic;    // R5, R6, R7
        load_status(8'hff);
        apply(5'd7, 8'hf0, 8'h0f, 3'd0, "R5");
        apply(5'd8, 8'h80, 8'h01, 3'd0, "R5");
        apply(5'd9, 8'haa, 8'haa, 3'd0, "R5");
        apply(5'd12, 8'h7f, 8'h00, 3'd0, "R6");
        apply(5'd13, 8'h80, 8'h00, 3'd0, "R6");
        apply(5'd12, 8'hff, 8'h00, 3'd0, "R6");
        apply(5'd10, 8'hff, 8'h00, 3'd0, "R7");
        apply(5'd11, 8'h80, 8'h00, 3'd0, "R7");
        apply(5'd11, 8'h00, 8'h00, 3'd0, "R7");
        apply(5'd11, 8'h01, 8'h00, 3'd0, "R7");
        for (int i = 0; i < 60; i++) begin
            load_status(8'($urandom()));
            apply(5'(7 + (i % 7)), 8'($urandom()), 8'($urandom()), 3'd0, "R5");
        end
    endtask

    task automatic t_shift;    // R8, R9
        load_status(8'h00);
        apply(5'd14, 8'h88, 8'h00, 3'd0, "R8");
        apply(5'd16, 8'h40, 8'h00, 3'd0, "R8");
        load_status(8'h01);
        apply(5'd17, 8'h02, 8'h00, 3'd0, "R9");
        apply(5'd18, 8'h81, 8'h00, 3'd0, "R9");
        apply(5'd15, 8'h01, 8'h00, 3'd0, "R9");
        for (int i = 0; i < 50; i++) begin
            load_status(8'($urandom()));
            apply(5'(14 + (i % 5)), 8'($urandom()), 8'h00, 3'd0, "R9");
        end
    endtask

    task automatic t_misc;     // R10, R11, R12
        load_status(8'h5a);
        apply(5'd19, 8'h3c, 8'h00, 3'd0, "R10");
        apply(5'd22, 8'h00, 8'hff, 3'd0, "R10");
        apply(5'd0, 8'hff, 8'hff, 3'd0, "R12");
        apply(5'd20, 8'h00, 8'h00, 3'd7, "R11");
        apply(5'd21, 8'h00, 8'h00, 3'd1, "R11");
        apply(5'd20, 8'h00, 8'h00, 3'd6, "R11");
    endtask

    initial begin
        #(5.0 * 200000);
        errs++;
        $display("FAIL watchdog expired");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        end
        $finish;
    end

    initial begin
        t_reset();
        t_addsub();
        t_compare();
        t_logic();
        t_shift();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        end
        $finish;
    end
endmodule